// File: doc/BRIEF.md
# Paged CSR Window Decoder

This block sits in front of a controller's control and status registers. The registers occupy a 16-bit internal offset space, but the bus only reaches them through a 12-bit local window. Local offsets below 0xC00 reach the internal register of the same offset. Local offsets from 0xC00 upward form a 1 KiB paged aperture. There the internal offset is built from a 6-bit page number, kept in a control register, and the low ten address bits. One small window therefore reaches 64 pages of register space.

Every access carries a byte size. The block checks the size and the alignment, performs legal accesses on byte lanes, and rejects illegal ones with a one-cycle error flag. It answers every request exactly one cycle later and also returns the expanded internal offset. The register file behind it is modelled as a small array whose entry is selected by the page bits and two word-address bits. The control register drives two transfer-enable outputs and the current page number.

A direct access to any other register clears the page number in hardware. Software therefore never finds a stale page after working in the unpaged region.

Top module: `csr_paged_window`

## Requirements
- R1: After reset the control register and every store entry read as zero, `page_sel`, `axi_pio_en`, `pcie_pio_en` and `rsp_valid` are low.
- R2: Every request cycle (`req_valid` high) produces `rsp_valid` high in the next cycle and in no other cycle; `rsp_offset` then holds the expanded internal offset of that request, and a write response carries zero read data.
- R3: A local offset below 0xC00 reaches the internal offset equal to the local offset; the page number plays no part.
- R4: A local offset of 0xC00 or more (local bits [11:10] both one) reaches internal offset {page number, local[9:0]}, where the page number is internal offset bits [15:10].
- R5: The control register lives at internal offset 0x808 (word 0x808..0x80B): bit 0 drives `axi_pio_en`, bit 1 drives `pcie_pio_en`, bits [18:13] hold the page number shown on `page_sel`, and the other bits are plain storage that reads back what was written.
- R6: A write to the page number applies to the very next request, including a request in the cycle right after the write.
- R7: An accepted access to a local offset below 0xC00 that does not hit the control word clears the page number to zero and leaves every other control bit unchanged.
- R8: Size codes 1, 2 and 4 (bytes) are legal; any other value of `req_size` is rejected with `rsp_err`.
- R9: A 2-byte access with address bit 0 set, or a 4-byte access with address bits [1:0] non-zero, is rejected with `rsp_err`.
- R10: A rejected access returns zero read data, writes nothing, does not clear the page number, and raises `rsp_err` only in its own response cycle.
- R11: Data uses byte lanes: byte lane b is bits [8b+7:8b]; an access covers lanes addr[1:0] up to addr[1:0]+size-1; writes change only covered lanes; reads return covered lanes with others zero.
- R12: A non-control internal offset selects store entry {offset[15:10], offset[3:2]}, so offsets that agree in those bits share one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Local byte offset in the window |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| req_wdata | input | 32 | Write data on byte lanes |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Previous request was rejected |
| rsp_rdata | output | 32 | Read data on byte lanes, zero on writes and errors |
| rsp_offset | output | 16 | Expanded internal offset of the last request |
| axi_pio_en | output | 1 | Control bit 0: system-side transfer enable |
| pcie_pio_en | output | 1 | Control bit 1: link-side transfer enable |
| page_sel | output | 6 | Current page number |

## Verification
The bench targets the window boundary: offsets 0xBFC and 0xC00 must fall on opposite sides, and a decoder that compared one bit too few would page the direct region or leave the aperture unpaged. It writes the page number and uses it in the very next cycle, which a design with an extra pipeline stage on the page would get wrong by using the stale page. It sends misaligned and odd-sized accesses to the control word and to direct registers, where a design that let a rejected access through would corrupt the page number or clear it. Sub-word writes that straddle the page bits show up any lane-merge error as a wrong page on `page_sel`, and a sweep of all 64 pages catches address aliasing and truncation of the page field.

// File: rtl/csr_pg_pkg.sv
package csr_pg_pkg;

   // legal access sizes, encoded as the byte count
   typedef enum logic [2:0] {
      SZ_BYTE = 3'd1,
      SZ_HALF = 3'd2,
      SZ_WORD = 3'd4
   } csr_size_e;

   // decode result for one request
   typedef struct packed {
      logic paged;
      logic hit_ctrl;
      logic ok;
   } csr_dec_t;

endpackage

// File: rtl/csr_pg_access_chk.sv
module csr_pg_access_chk
   import csr_pg_pkg::*;
#(
   parameter int BYTES = 4
) (
   input  logic [2:0]       size,
   input  logic [1:0]       lo,
   output logic             ok,
   output logic [BYTES-1:0] lanes
);

   always_comb begin
      ok    = 1'b0;
      lanes = '0;
      case (size)
         SZ_BYTE: begin
            ok    = 1'b1;
            lanes = BYTES'(1) << lo;
         end
         SZ_HALF: begin
            ok    = ~lo[0];
            lanes = BYTES'(3) << lo;
         end
         SZ_WORD: begin
            ok    = (lo == 2'b00);
            lanes = '1;
         end
         default: ok = 1'b0;
      endcase
      if (!ok) lanes = '0;
   end

endmodule

// File: rtl/csr_pg_xlat.sv
module csr_pg_xlat #(
   parameter int LOCAL_W  = 12,
   parameter int OFF_W    = 16,
   parameter int WIN_LO_W = 10
) (
   input  logic [LOCAL_W-1:0]        local_addr,
   input  logic [OFF_W-WIN_LO_W-1:0] page,
   output logic [OFF_W-1:0]          offset,
   output logic                      paged
);

   // the aperture is the top slice of the window: all select bits set
   assign paged  = &local_addr[LOCAL_W-1:WIN_LO_W];
   assign offset = paged ? {page, local_addr[WIN_LO_W-1:0]}
                         : OFF_W'(local_addr);

endmodule

// File: rtl/csr_pg_store.sv
module csr_pg_store #(
   parameter int DATA_W         = 32,
   parameter int IDX_W          = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [IDX_W-1:0]    idx,
   input  logic [DATA_W/8-1:0] lanes,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata
);

   localparam int DEPTH = 1 << IDX_W;
   localparam int BYTES = DATA_W / 8;

   logic [DATA_W-1:0] mem [DEPTH];

   assign rdata = mem[idx];

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (wr) begin
               for (int b = 0; b < BYTES; b++)
                  if (lanes[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (wr) begin
               for (int b = 0; b < BYTES; b++)
                  if (lanes[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/csr_paged_window.sv
module csr_paged_window
   import csr_pg_pkg::*;
#(
   parameter int          LOCAL_W     = 12,
   parameter int          OFF_W       = 16,
   parameter int          WIN_LO_W    = 10,
   parameter int          DATA_W      = 32,
   parameter int          PAGE_LSB    = 13,
   parameter int unsigned CTRL_OFF    = 32'h808,
   parameter int          KEEP_W      = 2,
   parameter bit          STORE_RESET = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic                         req_we,
   input  logic [LOCAL_W-1:0]           req_addr,
   input  logic [2:0]                   req_size,
   input  logic [DATA_W-1:0]            req_wdata,
   output logic                         rsp_valid,
   output logic                         rsp_err,
   output logic [DATA_W-1:0]            rsp_rdata,
   output logic [OFF_W-1:0]             rsp_offset,
   output logic                         axi_pio_en,
   output logic                         pcie_pio_en,
   output logic [OFF_W-WIN_LO_W-1:0]    page_sel
);

   localparam int PAGE_W = OFF_W - WIN_LO_W;
   localparam int BYTES  = DATA_W / 8;
   localparam int IDX_W  = PAGE_W + KEEP_W;
   localparam logic [OFF_W-1:0] CTRL_V = OFF_W'(CTRL_OFF);

   // elaboration-time parameter checks
   if (DATA_W != 32) begin : g_bad_data
      $error("csr_paged_window: size codes assume a 32-bit data path");
   end
   if (PAGE_LSB + PAGE_W > DATA_W) begin : g_bad_page
      $error("csr_paged_window: page field does not fit the control word");
   end
   if (LOCAL_W <= WIN_LO_W || OFF_W <= WIN_LO_W) begin : g_bad_win
      $error("csr_paged_window: window widths inconsistent");
   end
   if (KEEP_W < 1 || KEEP_W + 2 > WIN_LO_W) begin : g_bad_keep
      $error("csr_paged_window: store word bits out of range");
   end
   if (PAGE_LSB < 2) begin : g_bad_lsb
      $error("csr_paged_window: page field overlaps enable bits");
   end

   logic [DATA_W-1:0] ctrl_q, ctrl_d;
   logic [OFF_W-1:0]  req_off;
   logic [BYTES-1:0]  acc_lanes;
   logic [DATA_W-1:0] bitmask;
   logic [DATA_W-1:0] store_rdata, rd_word;
   logic [IDX_W-1:0]  store_idx;
   logic              accept, store_wr;
   csr_dec_t          dec;

   assign page_sel    = ctrl_q[PAGE_LSB +: PAGE_W];
   assign axi_pio_en  = ctrl_q[0];
   assign pcie_pio_en = ctrl_q[1];

   csr_pg_xlat #(
      .LOCAL_W (LOCAL_W),
      .OFF_W   (OFF_W),
      .WIN_LO_W(WIN_LO_W)
   ) u_xlat (
      .local_addr(req_addr),
      .page      (page_sel),
      .offset    (req_off),
      .paged     (dec.paged)
   );

   csr_pg_access_chk #(
      .BYTES(BYTES)
   ) u_acc (
      .size (req_size),
      .lo   (req_addr[1:0]),
      .ok   (dec.ok),
      .lanes(acc_lanes)
   );

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      assign bitmask[8*b +: 8] = {8{acc_lanes[b]}};
   end

   assign dec.hit_ctrl = (req_off[OFF_W-1:2] == CTRL_V[OFF_W-1:2]);
   assign accept       = req_valid & dec.ok;
   assign store_wr     = accept & req_we & ~dec.hit_ctrl;
   assign store_idx    = {req_off[OFF_W-1 -: PAGE_W], req_off[2 +: KEEP_W]};

   csr_pg_store #(
      .DATA_W        (DATA_W),
      .IDX_W         (IDX_W),
      .CLEAR_ON_RESET(STORE_RESET)
   ) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (store_wr),
      .idx  (store_idx),
      .lanes(acc_lanes),
      .wdata(req_wdata),
      .rdata(store_rdata)
   );

   // control word: lane writes, or page clear on a direct access elsewhere
   always_comb begin
      ctrl_d = ctrl_q;
      if (accept && dec.hit_ctrl && req_we)
         ctrl_d = (ctrl_q & ~bitmask) | (req_wdata & bitmask);
      else if (accept && !dec.paged && !dec.hit_ctrl)
         ctrl_d[PAGE_LSB +: PAGE_W] = '0;
   end

   assign rd_word = dec.hit_ctrl ? ctrl_q : store_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         rsp_valid  <= 1'b0;
         rsp_err    <= 1'b0;
         rsp_rdata  <= '0;
         rsp_offset <= '0;
      end else begin
         ctrl_q    <= ctrl_d;
         rsp_valid <= req_valid;
         rsp_err   <= req_valid & ~dec.ok;
         rsp_rdata <= (accept && !req_we) ? (rd_word & bitmask) : '0;
         if (req_valid) rsp_offset <= req_off;
      end
   end

endmodule

// File: rtl/csr_paged_window_chk.sv
module csr_paged_window_chk #(
   parameter int          LOCAL_W  = 12,
   parameter int          OFF_W    = 16,
   parameter int          WIN_LO_W = 10,
   parameter int          DATA_W   = 32,
   parameter int          PAGE_LSB = 13,
   parameter int unsigned CTRL_OFF = 32'h808
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      req_valid,
   input logic                      req_we,
   input logic [LOCAL_W-1:0]        req_addr,
   input logic [2:0]                req_size,
   input logic [DATA_W-1:0]         req_wdata,
   input logic                      rsp_valid,
   input logic                      rsp_err,
   input logic [DATA_W-1:0]         rsp_rdata,
   input logic [OFF_W-1:0]          rsp_offset,
   input logic                      axi_pio_en,
   input logic                      pcie_pio_en,
   input logic [OFF_W-WIN_LO_W-1:0] page_sel
);

   localparam int PAGE_W = OFF_W - WIN_LO_W;
   localparam logic [LOCAL_W-1:0] APERTURE = LOCAL_W'((1 << LOCAL_W) - (1 << WIN_LO_W));
   localparam logic [LOCAL_W-1:0] CTRL_L   = LOCAL_W'(CTRL_OFF);

   logic bad_req, dir_req, full_ctrl_wr;

   always_comb begin
      bad_req = req_valid &&
                !((req_size == 3'd1) ||
                  (req_size == 3'd2 && !req_addr[0]) ||
                  (req_size == 3'd4 && req_addr[1:0] == 2'b00));
      dir_req = req_valid && !bad_req && (req_addr < APERTURE) &&
                (req_addr[LOCAL_W-1:2] != CTRL_L[LOCAL_W-1:2]);
      full_ctrl_wr = req_valid && req_we && req_size == 3'd4 && req_addr == CTRL_L;
   end

   // R2
   rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R2
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R2
   wr_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_we) |=> rsp_rdata == '0);

   // R8 R9
   err_on_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_err == $past(bad_req)));

   // R10
   zero_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_rdata == '0);

   // R10
   bad_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_req |=> $stable(page_sel) && $stable(axi_pio_en) && $stable(pcie_pio_en));

   // R7
   direct_clears_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dir_req |=> (page_sel == '0) && $stable(axi_pio_en) && $stable(pcie_pio_en));

   // R3
   direct_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr < APERTURE) |=> rsp_offset == OFF_W'($past(req_addr)));

   // R4
   paged_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr >= APERTURE) |=>
         rsp_offset == {$past(page_sel), $past(req_addr[WIN_LO_W-1:0])});

   // R5
   ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_ctrl_wr |=> (axi_pio_en == $past(req_wdata[0])) &&
                       (pcie_pio_en == $past(req_wdata[1])) &&
                       (page_sel == $past(req_wdata[PAGE_LSB +: PAGE_W])));

   // R5
   page_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(page_sel));

endmodule

bind csr_paged_window csr_paged_window_chk #(
   .LOCAL_W (LOCAL_W),
   .OFF_W   (OFF_W),
   .WIN_LO_W(WIN_LO_W),
   .DATA_W  (DATA_W),
   .PAGE_LSB(PAGE_LSB),
   .CTRL_OFF(CTRL_OFF)
) u_chk (.*);

// File: tb/csr_paged_window_test.sv
module csr_paged_window_test;

   localparam int CLK_PERIOD = 10;
   localparam int CTRL_ADDR  = 'h808;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_we = 1'b0;
   logic [11:0] req_addr = '0;
   logic [2:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, rsp_err, axi_pio_en, pcie_pio_en;
   logic [31:0] rsp_rdata;
   logic [15:0] rsp_offset;
   logic [5:0]  page_sel;

   int  n_total = 0;
   int  n_bad   = 0;
   bit  done    = 1'b0;

   // reference model state
   logic [31:0] m_ctrl = '0;
   logic [31:0] m_mem [int];

   always #(CLK_PERIOD/2) clk = ~clk;

   csr_paged_window uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
      .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .rsp_offset(rsp_offset), .axi_pio_en(axi_pio_en),
      .pcie_pio_en(pcie_pio_en), .page_sel(page_sel)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // one clock of stimulus; called at a falling edge, returns at the next one
   task automatic step(input bit v, input bit we, input int addr, input int size,
                       input logic [31:0] wd, input string tag);
      int lo, page, off, key;
      bit ok, paged, hitc;
      logic [31:0] msk, word, e_rdata;
      req_valid = v; req_we = we; req_addr = 12'(addr);
      req_size = 3'(size); req_wdata = wd;
      lo    = addr % 4;
      page  = int'(m_ctrl[18:13]);
      ok    = (size == 1) || (size == 2 && lo % 2 == 0) || (size == 4 && lo == 0);
      msk   = '0;
      if (ok)
         for (int b = 0; b < 4; b++)
            if (b >= lo && b < lo + size) msk = msk | (32'hFF << (8*b));
      paged = (addr >= 'hC00);
      off   = paged ? page * 1024 + (addr % 1024) : addr;
      hitc  = (off / 4) == (CTRL_ADDR / 4);
      key   = (off / 1024) * 4 + (off / 4) % 4;
      word  = hitc ? m_ctrl : (m_mem.exists(key) ? m_mem[key] : 32'h0);
      e_rdata = (ok && !we) ? (word & msk) : 32'h0;
      if (v && ok) begin
         if (we) begin
            if (hitc) m_ctrl = (m_ctrl & ~msk) | (wd & msk);
            else      m_mem[key] = (word & ~msk) | (wd & msk);
         end
         if (!paged && !hitc) m_ctrl[18:13] = 6'd0;
      end
      @(posedge clk);
      @(negedge clk);
      check(tag, "rsp_valid", 32'(rsp_valid), 32'(v));
      if (v) begin
         check(tag, "rsp_err", 32'(rsp_err), 32'(!ok));
         check(tag, "rsp_rdata", rsp_rdata, e_rdata);
         check(tag, "rsp_offset", 32'(rsp_offset), 32'(off));
      end
      check(tag, "axi_pio_en", 32'(axi_pio_en), 32'(m_ctrl[0]));
      check(tag, "pcie_pio_en", 32'(pcie_pio_en), 32'(m_ctrl[1]));
      check(tag, "page_sel", 32'(page_sel), 32'(m_ctrl[18:13]));
      req_valid = 1'b0;
   endtask

   task automatic finish_run;
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs during and right after reset
      check("R1", "page_sel in reset", 32'(page_sel), 32'h0);
      check("R1", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "axi_pio_en", 32'(axi_pio_en), 32'h0);
      check("R1", "pcie_pio_en", 32'(pcie_pio_en), 32'h0);
      step(1'b0, 1'b0, 0, 4, 32'h0, "R2");
      step(1'b1, 1'b0, CTRL_ADDR, 4, 32'h0, "R1");
      step(1'b1, 1'b0, 'hC10, 4, 32'h0, "R1");
      step(1'b1, 1'b0, 'h3F8, 4, 32'h0, "R1");

      // R5 and R6: page write used in the very next cycle
      step(1'b1, 1'b1, CTRL_ADDR, 4, (32'd5 << 13) | 32'h3, "R5");
      step(1'b1, 1'b1, 'hC04, 4, 32'hA5A5_1234, "R6");
      step(1'b1, 1'b0, 'hC04, 4, 32'h0, "R4");
      step(1'b1, 1'b0, CTRL_ADDR, 4, 32'h0, "R5");
      step(1'b1, 1'b1, CTRL_ADDR, 4, 32'h5A00_0003 | (32'd5 << 13), "R5");
      step(1'b1, 1'b0, CTRL_ADDR, 4, 32'h0, "R5");

      // R11: sub-word writes straddling the page bits
      step(1'b1, 1'b1, 'h80A, 1, 32'h0002_0000, "R11");
      step(1'b1, 1'b1, CTRL_ADDR, 4, (32'd6 << 13) | 32'h3, "R5");
      step(1'b1, 1'b0, 'hC04, 4, 32'h0, "R12");
      step(1'b1, 1'b1, CTRL_ADDR, 2, (32'd5 << 13) | 32'h2, "R11");
      step(1'b1, 1'b0, 'hC06, 2, 32'h0, "R11");
      step(1'b1, 1'b0, 'hC05, 1, 32'h0, "R11");
      step(1'b1, 1'b1, 'hC07, 1, 32'h7700_0000, "R11");
      step(1'b1, 1'b0, 'hC04, 4, 32'h0, "R11");

      // R7 and R3: direct access clears the page, enables kept
      step(1'b1, 1'b1, CTRL_ADDR, 4, (32'd9 << 13) | 32'h1, "R5");
      step(1'b1, 1'b0, 'h004, 4, 32'h0, "R7");
      step(1'b1, 1'b1, 'h004, 4, 32'h1111_2222, "R3");
      step(1'b1, 1'b0, 'hC04, 4, 32'h0, "R12");

      // R9, R8, R10: rejected accesses
      step(1'b1, 1'b1, CTRL_ADDR, 4, (32'd9 << 13) | 32'h2, "R5");
      step(1'b1, 1'b1, 'h80A, 4, 32'hFFFF_FFFF, "R9");
      step(1'b1, 1'b0, 'h005, 2, 32'h0, "R9");
      step(1'b1, 1'b1, 'h006, 4, 32'hFFFF_FFFF, "R10");
      step(1'b1, 1'b0, 'h002, 4, 32'h0, "R10");
      step(1'b1, 1'b0, 'hC06, 4, 32'h0, "R9");
      step(1'b1, 1'b1, CTRL_ADDR, 3, 32'hFFFF_FFFF, "R8");
      step(1'b1, 1'b1, CTRL_ADDR, 0, 32'hFFFF_FFFF, "R8");
      step(1'b1, 1'b0, 'h004, 7, 32'h0, "R8");
      step(1'b1, 1'b0, 'h004, 4, 32'h0, "R10");
      step(1'b1, 1'b0, 'h007, 1, 32'h0, "R8");

      // R4 and R3: window boundary and the top page
      step(1'b1, 1'b1, CTRL_ADDR, 4, (32'd63 << 13) | 32'h1, "R4");
      step(1'b1, 1'b1, 'hFFC, 4, 32'hDEAD_BEEF, "R4");
      step(1'b1, 1'b0, 'hFFC, 4, 32'h0, "R4");
      step(1'b1, 1'b0, 'hBFC, 4, 32'h0, "R3");
      step(1'b1, 1'b0, 'hC00, 4, 32'h0, "R4");
      step(1'b0, 1'b0, 0, 4, 32'h0, "R2");
      step(1'b0, 1'b0, 0, 4, 32'h0, "R2");

      // R12: sweep all pages, then read back
      for (int p = 0; p < 64; p++) begin
         step(1'b1, 1'b1, CTRL_ADDR, 4, (32'(p) << 13) | 32'h3, "R6");
         step(1'b1, 1'b1, 'hC0C, 4, 32'hC0DE_0000 | 32'(p), "R12");
      end
      for (int p = 0; p < 64; p++) begin
         step(1'b1, 1'b1, CTRL_ADDR, 4, (32'(p) << 13), "R6");
         step(1'b1, 1'b0, 'hC0C, 4, 32'h0, "R12");
      end
      step(1'b1, 1'b0, 'h00C, 4, 32'h0, "R12");

      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_total++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

endmodule